// File: doc/BRIEF.md
# Modbus Serial Character Framer

This block is the character layer of a Modbus serial line. It has one transmitter and one receiver. They share a configuration that sets three things: the protocol variant, whether a parity bit is used, and whether parity is odd or even. The variant fixes the data length. The text variant uses 7 data bits and the binary variant uses 8. The parity setting fixes the stop-bit count, so every character is 10 bits long in the text variant and 11 bits long in the binary variant.

The transmitter accepts a byte through a valid/ready handshake and sends it least significant bit first. It starts with a low start bit and ends with high stop bits. The receiver synchronises the incoming line and oversamples it 16 times per bit. It samples each bit in the middle of the bit. For every character it delivers the rebuilt byte with a one-cycle strobe, together with a parity-error flag and a framing-error flag. In 7-bit mode the upper bit of the delivered byte is zero.

Bit timing comes from clock-enable dividers. A tick occurs every `CLK_PER_TICK` clocks and one bit lasts 16 ticks. The transmit divider restarts when a byte is accepted, so every transmitted bit is exactly the same length. Assembling messages, checksums and detecting silence between frames are left to the logic above this block.

Top module: `mbc_serdes`

## Requirements
- R1: After reset, `tx_line` is high, `tx_ready` is high and `rx_valid` is low.
- R2: An accepted byte starts on the clock edge after acceptance with one low start bit. The data bits follow least significant bit first, one per bit time.
- R3: When `cfg_rtu` is 0, only 7 data bits (bits 6..0) are sent, and bit 7 of `tx_data` has no effect on the line. When `cfg_rtu` is 1, all 8 bits are sent. The receiver delivers a 7-bit character zero-extended (`rx_data[7]` = 0).
- R4: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` = 0 the number of ones in data plus parity is even; with `cfg_par_odd` = 1 it is odd. When `cfg_par_en` is 0, no parity bit is sent.
- R5: One high stop bit follows when parity is enabled, and two high stop bits when it is disabled. `tx_ready` rises again exactly (frame bits × 16 × `CLK_PER_TICK`) clocks after the accepting edge.
- R6: While a character is being sent, `tx_ready` is low and `tx_valid` has no effect. No second character is produced, and the character in flight is not changed.
- R7: For each complete character the receiver raises `rx_valid` for exactly one clock. During that clock `rx_data` holds the received data.
- R8: `rx_par_err` is 1 with `rx_valid` when the received parity bit breaks the configured odd/even rule, and 0 otherwise.
- R9: `rx_frm_err` is 1 with `rx_valid` when any expected stop bit samples low.
- R10: A low pulse on `rx_line` that has returned high before the middle of the start bit is discarded, and no `rx_valid` follows.
- R11: Every transmitted bit lasts exactly 16 × `CLK_PER_TICK` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rtu | input | 1 | 1: 8 data bits; 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity; 0: even parity |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, accepts a byte |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input, asynchronous |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | One-cycle strobe for a received character |
| rx_par_err | output | 1 | Parity mismatch on the last character |
| rx_frm_err | output | 1 | Low stop bit on the last character |

## Verification
The first transmitted bit appears one clock after the accepting edge. Bit k of the frame therefore holds from edge k·BIT to edge (k+1)·BIT, where BIT is the bit time in clocks. The bench samples each bit BIT/2 clocks into it, one step after the edge. It checks `tx_ready` on both sides of edge n·BIT: low one edge before it and high right after it. The receiver answers within about one tick plus two synchroniser clocks after the middle of the last stop bit, which is well before the end of the frame. The bench therefore reads the strobe it captured a few clocks after `tx_ready` returns high. It checks that a discarded glitch produced nothing after waiting two full bit times.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    localparam int OVS    = 16;
    localparam int SUBW   = $clog2(OVS);
    localparam int FRW    = 11;
    localparam int IDXW   = 4;
    localparam logic [SUBW-1:0] SUB_END = SUBW'(OVS - 1);
    localparam logic [SUBW-1:0] SUB_MID = SUBW'(OVS / 2 - 1);

    typedef struct packed {
        logic rtu;
        logic par_en;
        logic par_odd;
    } mbc_cfg_t;

    typedef enum logic {TX_IDLE, TX_RUN} tx_st_e;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_SHIFT} rx_st_e;

    function automatic logic [7:0] mbc_mask(input logic rtu);
        return rtu ? 8'hFF : 8'h7F;
    endfunction

    function automatic logic [IDXW-1:0] mbc_ndata(input logic rtu);
        return rtu ? 4'd8 : 4'd7;
    endfunction

    // index of the final bit in the whole frame (start bit is index 0)
    function automatic logic [IDXW-1:0] mbc_last(input mbc_cfg_t c);
        return c.rtu ? 4'd10 : 4'd9;
    endfunction

    // line levels of one character, element 0 leaves first
    function automatic logic [FRW-1:0] mbc_frame(input logic [7:0] d, input mbc_cfg_t c);
        logic [FRW-1:0] f;
        logic [7:0]     m;
        logic           p;
        m = d & mbc_mask(c.rtu);
        p = (^m) ^ c.par_odd;
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (c.rtu || i < 7) f[i+1] = m[i];
        end
        if (c.par_en) begin
            if (c.rtu) f[9] = p;
            else       f[8] = p;
        end
        return f;
    endfunction

endpackage

// File: rtl/mbc_baud.sv
module mbc_baud #(
    parameter int CLK_PER_TICK = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(CLK_PER_TICK - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } baud_s_t;

    baud_s_t s_d, s_q;

    assign tick = (s_q.cnt == CNT_END);

    always_comb begin
        s_d = s_q;
        if (restart || tick) s_d.cnt = '0;
        else                 s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (CLK_PER_TICK > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R11
            AST_RESTART_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
                restart |=> !tick); // R11
        end
    endgenerate

endmodule

// File: rtl/mbc_tx.sv
module mbc_tx
    import mbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  mbc_cfg_t cfg,
    input  logic [7:0] data_i,
    input  logic     valid_i,
    output logic     ready_o,
    output logic     accept_o,
    output logic     line_o
);

    typedef struct packed {
        tx_st_e          st;
        logic [FRW-1:0]  sh;
        logic [IDXW-1:0] idx;
        logic [IDXW-1:0] last;
        logic [SUBW-1:0] sub;
        logic            line;
    } tx_s_t;

    tx_s_t s_d, s_q;
    logic [FRW-1:0] frame;

    assign frame    = mbc_frame(data_i, cfg);
    assign ready_o  = (s_q.st == TX_IDLE);
    assign accept_o = ready_o && valid_i;
    assign line_o   = s_q.line;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            TX_IDLE: begin
                s_d.line = 1'b1;
                if (valid_i) begin
                    s_d.st   = TX_RUN;
                    s_d.sh   = frame;
                    s_d.line = frame[0];
                    s_d.idx  = '0;
                    s_d.sub  = '0;
                    s_d.last = mbc_last(cfg);
                end
            end
            TX_RUN: begin
                if (tick) begin
                    if (s_q.sub == SUB_END) begin
                        s_d.sub = '0;
                        if (s_q.idx == s_q.last) begin
                            s_d.st   = TX_IDLE;
                            s_d.line = 1'b1;
                        end else begin
                            s_d.idx  = s_q.idx + 1'b1;
                            s_d.sh   = {1'b1, s_q.sh[FRW-1:1]};
                            s_d.line = s_q.sh[1];
                        end
                    end else begin
                        s_d.sub = s_q.sub + 1'b1;
                    end
                end
            end
            default: s_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= TX_IDLE;
            s_q.sh   <= '1;
            s_q.line <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> line_o); // R1
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !line_o); // R2
    AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(line_o)); // R5
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == TX_RUN) |-> !accept_o); // R6

endmodule

// File: rtl/mbc_rx.sv
module mbc_rx
    import mbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  mbc_cfg_t   cfg,
    input  logic       line_i,
    output logic [7:0] data_o,
    output logic       valid_o,
    output logic       par_err_o,
    output logic       frm_err_o
);

    typedef struct packed {
        rx_st_e          st;
        logic [1:0]      sync;
        logic [SUBW-1:0] sub;
        logic [IDXW-1:0] idx;
        mbc_cfg_t        cfg;
        logic [7:0]      sh;
        logic            par_acc;
        logic            pe;
        logic            fe;
        logic [7:0]      data;
        logic            valid;
        logic            par_err;
        logic            frm_err;
    } rx_s_t;

    rx_s_t s_d, s_q;
    logic            ln;
    logic [IDXW-1:0] ndata;
    logic [IDXW-1:0] last_idx;

    assign ln        = s_q.sync[1];
    assign ndata     = mbc_ndata(s_q.cfg.rtu);
    assign last_idx  = mbc_last(s_q.cfg) - 1'b1;
    assign data_o    = s_q.data;
    assign valid_o   = s_q.valid;
    assign par_err_o = s_q.par_err;
    assign frm_err_o = s_q.frm_err;

    always_comb begin
        logic [7:0] sh_n;
        logic       pe_n;
        logic       fe_n;
        s_d       = s_q;
        s_d.sync  = {s_q.sync[0], line_i};
        s_d.valid = 1'b0;
        sh_n      = s_q.sh;
        pe_n      = s_q.pe;
        fe_n      = s_q.fe;
        unique case (s_q.st)
            RX_IDLE: begin
                if (tick && !ln) begin
                    s_d.st  = RX_START;
                    s_d.sub = '0;
                    s_d.cfg = cfg;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (s_q.sub == SUB_MID) begin
                        if (ln) begin
                            s_d.st = RX_IDLE;
                        end else begin
                            s_d.st      = RX_SHIFT;
                            s_d.sub     = '0;
                            s_d.idx     = '0;
                            s_d.sh      = '0;
                            s_d.par_acc = 1'b0;
                            s_d.pe      = 1'b0;
                            s_d.fe      = 1'b0;
                        end
                    end else begin
                        s_d.sub = s_q.sub + 1'b1;
                    end
                end
            end
            RX_SHIFT: begin
                if (tick) begin
                    if (s_q.sub == SUB_END) begin
                        s_d.sub = '0;
                        if (s_q.idx < ndata) begin
                            sh_n        = {ln, s_q.sh[7:1]};
                            s_d.par_acc = s_q.par_acc ^ ln;
                        end else if (s_q.cfg.par_en && s_q.idx == ndata) begin
                            pe_n = (s_q.par_acc ^ ln) != s_q.cfg.par_odd;
                        end else if (!ln) begin
                            fe_n = 1'b1;
                        end
                        s_d.sh = sh_n;
                        s_d.pe = pe_n;
                        s_d.fe = fe_n;
                        if (s_q.idx == last_idx) begin
                            s_d.st      = RX_IDLE;
                            s_d.valid   = 1'b1;
                            s_d.data    = s_q.cfg.rtu ? sh_n : {1'b0, sh_n[7:1]};
                            s_d.par_err = pe_n;
                            s_d.frm_err = fe_n;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.sub = s_q.sub + 1'b1;
                    end
                end
            end
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= RX_IDLE;
            s_q.sync <= 2'b11;
        end else begin
            s_q <= s_d;
        end
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R7
    AST_SEVEN_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !s_q.cfg.rtu) |-> !data_o[7]); // R3
    AST_NO_PAR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !s_q.cfg.par_en) |-> !par_err_o); // R8
    AST_GLITCH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == RX_START && tick && s_q.sub == SUB_MID && ln) |=> (s_q.st == RX_IDLE && !valid_o)); // R10

endmodule

// File: rtl/mbc_serdes.sv
module mbc_serdes
    import mbc_pkg::*;
#(
    parameter int CLK_PER_TICK = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_rtu,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       tx_line,
    input  logic       rx_line,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    output logic       rx_par_err,
    output logic       rx_frm_err
);

    mbc_cfg_t cfg;
    logic     tx_tick;
    logic     rx_tick;
    logic     tx_accept;

    assign cfg = '{rtu: cfg_rtu, par_en: cfg_par_en, par_odd: cfg_par_odd};

    mbc_baud #(.CLK_PER_TICK(CLK_PER_TICK)) u_tx_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (tx_accept),
        .tick    (tx_tick)
    );

    mbc_baud #(.CLK_PER_TICK(CLK_PER_TICK)) u_rx_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (1'b0),
        .tick    (rx_tick)
    );

    mbc_tx u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tx_tick),
        .cfg      (cfg),
        .data_i   (tx_data),
        .valid_i  (tx_valid),
        .ready_o  (tx_ready),
        .accept_o (tx_accept),
        .line_o   (tx_line)
    );

    mbc_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (rx_tick),
        .cfg       (cfg),
        .line_i    (rx_line),
        .data_o    (rx_data),
        .valid_o   (rx_valid),
        .par_err_o (rx_par_err),
        .frm_err_o (rx_frm_err)
    );

endmodule

// File: tb/sim_mbc_serdes.sv
`timescale 1ns/1ps
module sim_mbc_serdes;

    localparam int DIV = 4;
    localparam int BIT = 16 * DIV;
    localparam int NV  = 8;
    // {rtu, par_en, par_odd, tx byte, expected rx byte}
    localparam logic [18:0] VEC [NV] = '{
        {3'b000, 8'h3A, 8'h3A},
        {3'b010, 8'h41, 8'h41},
        {3'b011, 8'h41, 8'h41},
        {3'b000, 8'hC5, 8'h45},
        {3'b100, 8'hA5, 8'hA5},
        {3'b110, 8'h01, 8'h01},
        {3'b111, 8'hFF, 8'hFF},
        {3'b100, 8'h80, 8'h80}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_rtu = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [7:0] tx_data = '0;
    logic tx_valid = 1'b0;
    logic tx_ready, tx_line, rx_line;
    logic [7:0] rx_data;
    logic rx_valid, rx_par_err, rx_frm_err;
    logic loop_en = 1'b1;
    logic drv_line = 1'b1;

    int n_tests = 0, n_fail = 0, rx_cnt = 0;
    logic [7:0] cap_data = '0;
    logic cap_pe = 1'b0, cap_fe = 1'b0;
    bit finished = 0;

    assign rx_line = loop_en ? tx_line : drv_line;

    always #5 clk = ~clk;

    mbc_serdes #(.CLK_PER_TICK(DIV)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_rtu(cfg_rtu), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_line(tx_line),
        .rx_line(rx_line), .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            rx_cnt   <= rx_cnt + 1;
            cap_data <= rx_data;
            cap_pe   <= rx_par_err;
            cap_fe   <= rx_frm_err;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    function automatic logic [10:0] exp_frame(input logic [7:0] d, input logic [2:0] c);
        logic [10:0] f;
        int nd;
        logic p;
        nd = c[2] ? 8 : 7;
        p = c[0];
        f = '1;
        f[0] = 1'b0;
        for (int i = 0; i < nd; i++) begin
            f[i+1] = d[i];
            p = p ^ d[i];
        end
        if (c[1]) f[nd+1] = p;
        return f;
    endfunction

    task automatic set_cfg(input logic [2:0] c);
        @(negedge clk);
        {cfg_rtu, cfg_par_en, cfg_par_odd} = c;
    endtask

    // offers a byte, samples every bit mid-way, checks ready around frame end
    task automatic send(input logic [7:0] d, input logic [2:0] c,
                        output logic [10:0] obs, output logic r_before, output logic r_after);
        int nb;
        nb = c[2] ? 11 : 10;
        obs = '1;
        set_cfg(c);
        tx_data = d;
        tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        for (int k = 0; k < nb; k++) begin
            repeat ((k == 0) ? BIT / 2 : BIT) @(posedge clk);
            #1 obs[k] = tx_line;
        end
        repeat (BIT / 2 - 1) @(posedge clk);
        #1 r_before = tx_ready;
        @(posedge clk);
        #1 r_after = tx_ready;
    endtask

    task automatic drive_frame(input logic [10:0] f, input int nb);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            drv_line = f[k];
            repeat (BIT - 1) @(negedge clk);
        end
        @(negedge clk);
        drv_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [10:0] obs, ef;
        logic rb, ra;
        int c0;

        repeat (5) @(posedge clk);
        #1;
        chk(tx_line === 1'b1, "R1 idle line", int'(tx_line), 1);
        chk(tx_ready === 1'b1, "R1 ready under reset", int'(tx_ready), 1);
        @(negedge clk) rst_n = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk(tx_line === 1'b1 && tx_ready === 1'b1 && rx_valid === 1'b0,
            "R1 idle after reset", {tx_line, tx_ready, rx_valid}, 3'b110);

        // vector table over every variant, looped back into the receiver
        for (int v = 0; v < NV; v++) begin
            c0 = rx_cnt;
            send(VEC[v][15:8], VEC[v][18:16], obs, rb, ra);
            ef = exp_frame(VEC[v][15:8], VEC[v][18:16]);
            chk(obs === ef, "R2 R3 R4 R5 frame bits", int'(obs), int'(ef));
            chk(rb === 1'b0 && ra === 1'b1, "R5 ready timing", {rb, ra}, 2'b01);
            repeat (4) @(posedge clk);
            #1;
            chk(rx_cnt == c0 + 1, "R7 one strobe", rx_cnt - c0, 1);
            chk(cap_data === VEC[v][7:0], "R7 R3 rx data", int'(cap_data), int'(VEC[v][7:0]));
            chk(cap_pe === 1'b0 && cap_fe === 1'b0, "R8 R9 clean flags", {cap_pe, cap_fe}, 0);
        end

        // R11: start bit lasts exactly one bit time
        set_cfg(3'b100);
        tx_data = 8'h01;
        tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        repeat (BIT - 1) @(posedge clk);
        #1 chk(tx_line === 1'b0, "R11 start held to last clock", int'(tx_line), 0);
        @(posedge clk);
        #1 chk(tx_line === 1'b1, "R11 first data at bit edge", int'(tx_line), 1);
        wait (tx_ready === 1'b1);
        repeat (2 * BIT) @(posedge clk);

        // R6: offer during busy is ignored
        c0 = rx_cnt;
        set_cfg(3'b100);
        tx_data = 8'h3C;
        tx_valid = 1'b1;
        @(posedge clk);
        #1 tx_valid = 1'b0;
        repeat (2 * BIT) @(posedge clk);
        #1 chk(tx_ready === 1'b0, "R6 ready low while busy", int'(tx_ready), 0);
        tx_data = 8'hC3;
        tx_valid = 1'b1;
        repeat (20) @(posedge clk);
        #1 tx_valid = 1'b0;
        wait (tx_ready === 1'b1);
        repeat (3 * BIT) @(posedge clk);
        #1;
        chk(rx_cnt == c0 + 1, "R6 single character", rx_cnt - c0, 1);
        chk(cap_data === 8'h3C, "R6 character unchanged", int'(cap_data), 'h3C);
        chk(tx_line === 1'b1, "R6 line idle after", int'(tx_line), 1);

        // receiver tests driven directly
        loop_en = 1'b0;

        // R8: wrong parity, text variant even parity
        c0 = rx_cnt;
        set_cfg(3'b010);
        ef = exp_frame(8'h41, 3'b010);
        ef[8] = ~ef[8];
        drive_frame(ef, 10);
        chk(rx_cnt == c0 + 1, "R8 strobe", rx_cnt - c0, 1);
        chk(cap_pe === 1'b1 && cap_fe === 1'b0, "R8 parity error", {cap_pe, cap_fe}, 2'b10);
        chk(cap_data === 8'h41, "R8 data kept", int'(cap_data), 'h41);

        // R9: first of two stop bits low, binary variant
        c0 = rx_cnt;
        set_cfg(3'b100);
        ef = exp_frame(8'h5A, 3'b100);
        ef[9] = 1'b0;
        drive_frame(ef, 11);
        chk(rx_cnt == c0 + 1, "R9 strobe", rx_cnt - c0, 1);
        chk(cap_fe === 1'b1 && cap_pe === 1'b0, "R9 framing error", {cap_pe, cap_fe}, 2'b01);

        // R10: short low glitch
        c0 = rx_cnt;
        @(negedge clk);
        drv_line = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        drv_line = 1'b1;
        repeat (2 * BIT) @(negedge clk);
        chk(rx_cnt == c0, "R10 glitch discarded", rx_cnt - c0, 0);

        // receiver still works after the glitch
        c0 = rx_cnt;
        set_cfg(3'b011);
        drive_frame(exp_frame(8'h7E, 3'b011), 10);
        chk(rx_cnt == c0 + 1 && cap_data === 8'h7E && !cap_pe && !cap_fe,
            "R10 R7 recovery", int'(cap_data), 'h7E);

        finish_run();
    end

endmodule